// File: doc/BRIEF.md
# ISA Host Bus and DMA Handshake Front End

This block is the host-facing bus front end of a floppy-style disk controller on an ISA-like bus. It brings the asynchronous bus strobes, address enable, DMA acknowledge and terminal count into the core clock domain. It latches the 10-bit I/O address when a read or write strobe begins. From that latched address it produces a register select plus read and write enables for the controller core. Programmed-I/O decoding is suppressed while address enable marks a DMA cycle.

On the DMA side, the core asks for a single-byte transfer with a one-clock request pulse, and the block raises the bus DMA request. The request is withdrawn when the acknowledge falls. If the acknowledge is already held low, as in demand transfers, the request is instead withdrawn by the falling edge of the read strobe. DMA data enables follow the acknowledge. Terminal count is only accepted while the acknowledge is low, and its active level depends on a 2-bit system-mode input. An accepted terminal count yields a one-clock transfer-done pulse and cancels the outstanding request.

The data bus is split into a value and an output-enable. A pad outside the block turns these into the tri-state bus.

Top module: `isa_dma_front`

## Requirements
- R1: After reset, `bus_drq`, `xfer_done`, `data_oe` and all four enables are 0.
- R2: The address is captured when a strobe first goes low. Address changes made later in the same strobe do not alter `reg_sel`.
- R3: A programmed-I/O access hits when latched address bits 9:3 equal bits 9:3 of `BASE_ADDR` (default 0x3F0). `reg_sel` is then latched bits 2:0. `reg_rd_en` or `reg_wr_en` is 1 while the matching strobe is held, and an address outside the window gives no enable.
- R4: While `bus_aen` is 1, `reg_rd_en` and `reg_wr_en` stay 0.
- R5: `data_oe` is 1, with `data_out` equal to `core_rd_data`, only during a decoded programmed-I/O read or a DMA read. At all other times it is 0.
- R6: `dma_rd_en` and `dma_wr_en` follow the read and write strobes only while `bus_dack_n` is 0.
- R7: A `core_req` pulse sets `bus_drq` on the next clock edge. A falling `bus_dack_n` clears it.
- R8: When `bus_dack_n` is already low, a falling read strobe clears `bus_drq`. A falling write strobe does not.
- R9: Terminal count has no effect while `bus_dack_n` is 1.
- R10: `cfg_mode` 00 (AT), 10 (model 30) and 11 (treated like AT) take `bus_tc` as active high. `cfg_mode` 01 (PS/2) takes it as active low.
- R11: An accepted terminal count gives exactly one `xfer_done` cycle and clears `bus_drq`. A `core_req` arriving while the accepted count persists is ignored.
- R12: A bus input change sampled at clock edge k first shows on the enables and on `bus_drq` after edge k+2. Outputs do not change before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | System mode: 00 AT, 01 PS/2, 10 model 30, 11 as AT |
| bus_addr | input | 10 | Host I/O address |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_aen | input | 1 | Address enable, high during DMA cycles |
| bus_dack_n | input | 1 | DMA acknowledge, active low |
| bus_tc | input | 1 | Terminal count, polarity from `cfg_mode` |
| core_req | input | 1 | One-clock request for a byte transfer |
| core_rd_data | input | 8 | Byte the core presents for host reads |
| bus_drq | output | 1 | DMA request to the host |
| data_out | output | 8 | Byte for the data bus pad |
| data_oe | output | 1 | Data bus pad output enable |
| reg_sel | output | 3 | Register offset within the decoded window |
| reg_rd_en | output | 1 | Programmed-I/O read enable |
| reg_wr_en | output | 1 | Programmed-I/O write enable |
| dma_rd_en | output | 1 | DMA read data enable |
| dma_wr_en | output | 1 | DMA write data enable |
| xfer_done | output | 1 | One-clock pulse on accepted terminal count |

## Verification
A core request and an accepted terminal count can meet in the same cycle, and each pulls `bus_drq` a different way. The bench holds the acknowledge low with terminal count at its active level, then issues `core_req`. The result is judged by `bus_drq` staying 0 and by `xfer_done` having pulsed exactly once. A second overlap puts a falling read strobe on an already-low acknowledge while a DMA request is pending. In that case the request must drop and `dma_rd_en` must rise together.

// File: rtl/isa_front_pkg.sv
package isa_front_pkg;

    localparam int ADDR_W = 10;
    localparam int SEL_W  = 3;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_AT  = 2'b00,
        MODE_PS2 = 2'b01,
        MODE_M30 = 2'b10,
        MODE_RSV = 2'b11
    } sys_mode_e;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic aen;
        logic dack_n;
        logic tc;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, aen: 1'b0,
                                  dack_n: 1'b1, tc: 1'b0};

    typedef struct packed {
        logic rd_fall;
        logic wr_fall;
        logic dack_fall;
    } edge_t;

    function automatic logic tc_asserted(sys_mode_e m, logic tc);
        return (m == MODE_PS2) ? ~tc : tc;
    endfunction

    function automatic edge_t find_edges(ctl_t now, ctl_t prev);
        edge_t e;
        e.rd_fall   = prev.rd_n   & ~now.rd_n;
        e.wr_fall   = prev.wr_n   & ~now.wr_n;
        e.dack_fall = prev.dack_n & ~now.dack_n;
        return e;
    endfunction

endpackage

// File: rtl/isa_sync_bank.sv
module isa_sync_bank #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= INIT[i];
                q_sync[i] <= INIT[i];
            end else begin
                stage1[i] <= d_async[i];
                q_sync[i] <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/isa_cycle_decode.sv
module isa_cycle_decode
    import isa_front_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h3F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_s,
    input  ctl_t              ctl_s,
    input  edge_t             edges,
    output logic [SEL_W-1:0]  reg_sel,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic              dma_rd_en,
    output logic              dma_wr_en
);
    localparam int HI_W = ADDR_W - SEL_W;

    logic [ADDR_W-1:0] lat_addr;
    logic              cyc_rd;
    logic              cyc_wr;
    logic              win_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_addr <= '0;
            cyc_rd   <= 1'b0;
            cyc_wr   <= 1'b0;
        end else begin
            if (edges.rd_fall || edges.wr_fall)
                lat_addr <= addr_s;

            if (edges.rd_fall)
                cyc_rd <= 1'b1;
            else if (ctl_s.rd_n)
                cyc_rd <= 1'b0;

            if (edges.wr_fall)
                cyc_wr <= 1'b1;
            else if (ctl_s.wr_n)
                cyc_wr <= 1'b0;
        end
    end

    assign win_hit   = (lat_addr[ADDR_W-1 -: HI_W] == BASE_ADDR[ADDR_W-1 -: HI_W]);
    assign reg_sel   = lat_addr[SEL_W-1:0];
    assign reg_rd_en = cyc_rd & win_hit & ~ctl_s.aen;
    assign reg_wr_en = cyc_wr & win_hit & ~ctl_s.aen;
    assign dma_rd_en = cyc_rd & ~ctl_s.dack_n;
    assign dma_wr_en = cyc_wr & ~ctl_s.dack_n;
endmodule

// File: rtl/isa_dma_ctrl.sv
module isa_dma_ctrl
    import isa_front_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sys_mode_e mode,
    input  ctl_t      ctl_s,
    input  edge_t     edges,
    input  logic      core_req,
    output logic      drq,
    output logic      xfer_done
);
    logic tc_acc;
    logic tc_acc_q;
    logic demand_rd;

    assign tc_acc    = ~ctl_s.dack_n & tc_asserted(mode, ctl_s.tc);
    assign demand_rd = ~ctl_s.dack_n & ~edges.dack_fall & edges.rd_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_acc_q  <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            tc_acc_q  <= tc_acc;
            xfer_done <= tc_acc & ~tc_acc_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            drq <= 1'b0;
        else if (tc_acc)
            drq <= 1'b0;
        else if (core_req)
            drq <= 1'b1;
        else if (edges.dack_fall || demand_rd)
            drq <= 1'b0;
    end
endmodule

// File: rtl/isa_dma_front.sv
module isa_dma_front
    import isa_front_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h3F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              bus_aen,
    input  logic              bus_dack_n,
    input  logic              bus_tc,
    input  logic              core_req,
    input  logic [DATA_W-1:0] core_rd_data,
    output logic              bus_drq,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [SEL_W-1:0]  reg_sel,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic              dma_rd_en,
    output logic              dma_wr_en,
    output logic              xfer_done
);
    localparam int CTL_W = $bits(ctl_t);

    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    ctl_t              ctl_prev;
    edge_t             edges;
    logic [ADDR_W-1:0] addr_s;
    sys_mode_e         mode;

    assign ctl_raw = '{rd_n: bus_rd_n, wr_n: bus_wr_n, aen: bus_aen,
                       dack_n: bus_dack_n, tc: bus_tc};
    assign mode    = sys_mode_e'(cfg_mode);

    isa_sync_bank #(.W(CTL_W), .INIT(CTL_IDLE)) i_ctl_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ctl_raw),
        .q_sync  (ctl_s)
    );

    isa_sync_bank #(.W(ADDR_W), .INIT('0)) i_addr_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (bus_addr),
        .q_sync  (addr_s)
    );

    always_ff @(posedge clk) begin
        if (rst) ctl_prev <= CTL_IDLE;
        else     ctl_prev <= ctl_s;
    end

    assign edges = find_edges(ctl_s, ctl_prev);

    isa_cycle_decode #(.BASE_ADDR(BASE_ADDR)) i_decode (
        .clk       (clk),
        .rst       (rst),
        .addr_s    (addr_s),
        .ctl_s     (ctl_s),
        .edges     (edges),
        .reg_sel   (reg_sel),
        .reg_rd_en (reg_rd_en),
        .reg_wr_en (reg_wr_en),
        .dma_rd_en (dma_rd_en),
        .dma_wr_en (dma_wr_en)
    );

    isa_dma_ctrl i_dma (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .ctl_s     (ctl_s),
        .edges     (edges),
        .core_req  (core_req),
        .drq       (bus_drq),
        .xfer_done (xfer_done)
    );

    assign data_oe  = reg_rd_en | dma_rd_en;
    assign data_out = core_rd_data;
endmodule

// File: rtl/isa_dma_front_chk.sv
module isa_dma_front_chk (
    input logic clk,
    input logic rst,
    input logic bus_rd_n,
    input logic bus_aen,
    input logic bus_dack_n,
    input logic core_req,
    input logic bus_drq,
    input logic data_oe,
    input logic reg_rd_en,
    input logic reg_wr_en,
    input logic dma_rd_en,
    input logic dma_wr_en,
    input logic xfer_done
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);                                          // R11
    AST_DONE_DROPS_DRQ: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !bus_drq);                                            // R11
    AST_DRQ_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_drq) |-> $past(core_req));                                // R7
    AST_DMA_NEEDS_DACK: assert property (@(posedge clk) disable iff (rst)
        (dma_rd_en || dma_wr_en) |-> !$past(bus_dack_n, 2));                // R6
    AST_PIO_NOT_IN_DMA: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en || reg_wr_en) |-> !$past(bus_aen, 2));                   // R4
    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !$past(bus_rd_n, 3));                                   // R5
endmodule

bind isa_dma_front isa_dma_front_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rd_n   (bus_rd_n),
    .bus_aen    (bus_aen),
    .bus_dack_n (bus_dack_n),
    .core_req   (core_req),
    .bus_drq    (bus_drq),
    .data_oe    (data_oe),
    .reg_rd_en  (reg_rd_en),
    .reg_wr_en  (reg_wr_en),
    .dma_rd_en  (dma_rd_en),
    .dma_wr_en  (dma_wr_en),
    .xfer_done  (xfer_done)
);

// File: tb/test_isa_dma_front.sv
`timescale 1ns/1ps
module test_isa_dma_front;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic [9:0] bus_addr = '0;
    logic       bus_rd_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic       bus_aen = 1'b0;
    logic       bus_dack_n = 1'b1;
    logic       bus_tc = 1'b0;
    logic       core_req = 1'b0;
    logic [7:0] core_rd_data = 8'hA5;
    logic       bus_drq;
    logic [7:0] data_out;
    logic       data_oe;
    logic [2:0] reg_sel;
    logic       reg_rd_en, reg_wr_en, dma_rd_en, dma_wr_en, xfer_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    isa_dma_front i_isa_dma_front (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .bus_addr(bus_addr),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_aen(bus_aen),
        .bus_dack_n(bus_dack_n), .bus_tc(bus_tc), .core_req(core_req),
        .core_rd_data(core_rd_data), .bus_drq(bus_drq), .data_out(data_out),
        .data_oe(data_oe), .reg_sel(reg_sel), .reg_rd_en(reg_rd_en),
        .reg_wr_en(reg_wr_en), .dma_rd_en(dma_rd_en), .dma_wr_en(dma_wr_en),
        .xfer_done(xfer_done)
    );

    always @(negedge clk) begin
        if (xfer_done) done_cnt++;
        cycles++;
    end

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_req();
        @(negedge clk) core_req = 1'b1;
        @(negedge clk) core_req = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 drq", bus_drq, 0);
        check("R1 done", xfer_done, 0);
        check("R1 oe", data_oe, 0);
        check("R1 enables", {reg_rd_en, reg_wr_en, dma_rd_en, dma_wr_en}, 0);
    endtask

    task automatic t_pio_read();
        @(negedge clk) begin bus_addr = 10'h3F5; bus_rd_n = 1'b0; end
        step(2);
        check("R12 early", reg_rd_en, 0);
        step(1);
        check("R12 rd_en", reg_rd_en, 1);
        check("R3 sel", reg_sel, 5);
        check("R5 oe", data_oe, 1);
        check("R5 data", data_out, 8'hA5);
        @(negedge clk) bus_addr = 10'h3F2;
        step(4);
        check("R2 sel held", reg_sel, 5);
        @(negedge clk) bus_rd_n = 1'b1;
        step(3);
        check("R5 oe off", data_oe, 0);
        check("R3 rd_en off", reg_rd_en, 0);
    endtask

    task automatic t_pio_write();
        @(negedge clk) begin bus_addr = 10'h2F5; bus_wr_n = 1'b0; end
        step(3);
        check("R3 miss", reg_wr_en, 0);
        @(negedge clk) bus_wr_n = 1'b1;
        step(3);
        @(negedge clk) begin bus_addr = 10'h3F1; bus_wr_n = 1'b0; end
        step(3);
        check("R3 wr hit", reg_wr_en, 1);
        check("R3 wr sel", reg_sel, 1);
        check("R5 no oe on write", data_oe, 0);
        @(negedge clk) bus_wr_n = 1'b1;
        step(3);
    endtask

    task automatic t_aen();
        @(negedge clk) begin bus_aen = 1'b1; bus_addr = 10'h3F3; bus_rd_n = 1'b0; end
        step(3);
        check("R4 rd_en", reg_rd_en, 0);
        check("R6 no dack", dma_rd_en, 0);
        check("R5 oe", data_oe, 0);
        @(negedge clk) begin bus_rd_n = 1'b1; bus_aen = 1'b0; end
        step(3);
    endtask

    task automatic t_dma_normal();
        pulse_req();
        check("R7 set", bus_drq, 1);
        @(negedge clk) begin bus_aen = 1'b1; bus_dack_n = 1'b0; end
        step(2);
        check("R12 drq early", bus_drq, 1);
        step(1);
        check("R7 clear on dack", bus_drq, 0);
        @(negedge clk) bus_rd_n = 1'b0;
        step(3);
        check("R6 dma rd", dma_rd_en, 1);
        check("R5 oe dma", data_oe, 1);
        @(negedge clk) begin bus_rd_n = 1'b1; bus_dack_n = 1'b1; bus_aen = 1'b0; end
        step(3);
        check("R6 dma rd off", dma_rd_en, 0);
    endtask

    task automatic t_demand();
        @(negedge clk) begin bus_aen = 1'b1; bus_dack_n = 1'b0; end
        step(3);
        pulse_req();
        check("R8 set with dack low", bus_drq, 1);
        @(negedge clk) bus_wr_n = 1'b0;
        step(3);
        check("R8 write keeps drq", bus_drq, 1);
        check("R6 dma wr", dma_wr_en, 1);
        @(negedge clk) bus_wr_n = 1'b1;
        step(3);
        @(negedge clk) bus_rd_n = 1'b0;
        step(3);
        check("R8 read clears", bus_drq, 0);
        check("R8 dma rd same", dma_rd_en, 1);
        @(negedge clk) begin bus_rd_n = 1'b1; bus_dack_n = 1'b1; bus_aen = 1'b0; end
        step(3);
    endtask

    task automatic t_tc_ignored();
        @(negedge clk) begin cfg_mode = 2'b00; bus_tc = 1'b1; end
        step(3);
        done_cnt = 0;
        pulse_req();
        step(5);
        check("R9 drq kept", bus_drq, 1);
        check("R9 no done", done_cnt, 0);
        @(negedge clk) bus_dack_n = 1'b0;
        step(3);
        @(negedge clk) begin bus_dack_n = 1'b1; bus_tc = 1'b0; end
        step(3);
        done_cnt = 0;
    endtask

    task automatic t_tc_mode(logic [1:0] m, logic act, string tag);
        @(negedge clk) begin cfg_mode = m; bus_tc = ~act; bus_dack_n = 1'b1; end
        step(3);
        @(negedge clk) bus_dack_n = 1'b0;
        step(3);
        done_cnt = 0;
        pulse_req();
        step(4);
        check({"R10 inactive ", tag}, done_cnt, 0);
        check({"R10 drq held ", tag}, bus_drq, 1);
        @(negedge clk) bus_tc = act;
        step(3);
        check({"R11 drq cleared ", tag}, bus_drq, 0);
        pulse_req();
        step(3);
        check({"R11 req ignored ", tag}, bus_drq, 0);
        check({"R11 one pulse ", tag}, done_cnt, 1);
        @(negedge clk) begin bus_dack_n = 1'b1; bus_tc = ~act; end
        step(3);
    endtask

    initial begin
        step(3);
        @(negedge clk) rst = 1'b0;
        step(1);
        t_reset();
        t_pio_read();
        t_pio_write();
        t_aen();
        t_dma_normal();
        t_demand();
        t_tc_ignored();
        t_tc_mode(2'b00, 1'b1, "at");
        t_tc_mode(2'b01, 1'b0, "ps2");
        t_tc_mode(2'b10, 1'b1, "m30");
        t_tc_mode(2'b11, 1'b1, "rsv");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule